// File: doc/BRIEF.md
# Bit-Serial Accumulator ALU

This block is the arithmetic and logic core of a small accumulator machine that handles data one bit per clock. Two operand streams enter it, least significant bit first: `aIn` carries the accumulator and `bIn` carries the memory operand. Each bit time produces one result bit on `fOut`. A single carry flip-flop links one bit time to the next, so an 8-bit word takes eight bit times.

A 3-bit opcode is decoded into a small control word. The control word gates and inverts each operand, enables or blocks the carry chain, sets the carry value used at the start of a word, and selects one of four output functions: zero, XOR/sum, AND or OR. One output mux therefore serves both the logic and the arithmetic instructions.

`bitValid` marks the cycles that carry a real bit. `wordStart` is raised together with `bitValid` on the first (least significant) bit of a word. Shift registers, memory and sequencing are outside the block.

Top module: `serialAlu`

## Requirements
- R1: While `rstN` is low, and after it is released, `carryOut` reads 0 and the carry chain starts cleared. A reset in the middle of a sequence clears `carryOut` at once.
- R2: Opcode 001 gives the bitwise AND of A and B, opcode 010 gives OR and opcode 011 gives XOR. All three leave `carryOut` at 0.
- R3: Opcode 100 (add) gives the low 8 bits of A+B on `fOut`, least significant bit first. After the eighth bit, `carryOut` holds the carry out of bit 7.
- R4: Opcode 101 (subtract) gives the low 8 bits of A−B. B is inverted and the carry is preset to 1 on the first bit. After the eighth bit, `carryOut` is 1 exactly when A ≥ B (no borrow).
- R5: Opcode 000 passes B to `fOut` unchanged, opcode 110 passes A unchanged, and opcode 111 outputs zero on every bit. None of these sets `carryOut`.
- R6: A logic or pass operation that follows an arithmetic word that left the carry at 1 is not corrupted by that carry, and it returns `carryOut` to 0.
- R7: A bit flagged with `wordStart` uses the opcode's preset carry (0 for add, 1 for subtract) and ignores whatever carry the previous word left behind.
- R8: A cycle with `bitValid` low changes neither the carry, the bit position nor `carryOut`. A word split by idle cycles, with arbitrary operand values during those cycles, gives the same result as an unbroken word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | The current cycle carries an operand bit |
| wordStart | input | 1 | First (LSB) bit of a word; only sampled with `bitValid` |
| aIn | input | 1 | Serial accumulator operand bit |
| bIn | input | 1 | Serial memory operand bit |
| opcode | input | 3 | Instruction: 000 load, 001 and, 010 or, 011 xor, 100 add, 101 sub, 110 store, 111 jump (zero) |
| fOut | output | 1 | Serial result bit for the current bit time (combinational) |
| carryOut | output | 1 | Carry left by the eighth bit of the last completed word |

## Verification
Two things can happen in the same cycle: a new word's start-of-word preset, and the carry that the previous word stored in the flip-flop. The bench provokes this by ending one word with an add that carries out of bit 7 and then starting an add or a subtract at once. It judges both the new word's bit stream and its final `carryOut` against values computed from plain integer arithmetic. A logic word placed straight after a carrying add checks the same collision for the carry-suppression path. A word split by idle cycles with garbage operands shows that the hold condition and the carry chain do not interfere.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'b000,
    OP_AND   = 3'b001,
    OP_OR    = 3'b010,
    OP_XOR   = 3'b011,
    OP_ADD   = 3'b100,
    OP_SUB   = 3'b101,
    OP_STORE = 3'b110,
    OP_JUMP  = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ZERO = 2'b00,
    FN_XOR  = 2'b01,
    FN_AND  = 2'b10,
    FN_OR   = 2'b11
  } func_e;

  // Control word sent from the decoder to the datapath
  typedef struct packed {
    logic  passA;       // gate A operand through (else forced to 0)
    logic  passB;       // gate B operand through (else forced to 0)
    logic  invA;        // invert A after gating
    logic  invB;        // invert B after gating
    logic  carryEn;     // carry chain active
    logic  carryPreset; // carry value used on the first bit of a word
    func_e func;        // output mux select
  } alu_ctrl_t;

endpackage

// File: rtl/serialAluDecode.sv
module serialAluDecode
  import serial_alu_pkg::*;
(
  input  logic [2:0] opcode,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{passA: 1'b1, passB: 1'b1, invA: 1'b0, invB: 1'b0,
             carryEn: 1'b0, carryPreset: 1'b0, func: FN_ZERO};
    unique case (opcode_e'(opcode))
      OP_LOAD:  begin ctrl.passA = 1'b0; ctrl.func = FN_XOR; end
      OP_AND:   ctrl.func = FN_AND;
      OP_OR:    ctrl.func = FN_OR;
      OP_XOR:   ctrl.func = FN_XOR;
      OP_ADD:   begin ctrl.func = FN_XOR; ctrl.carryEn = 1'b1; end
      OP_SUB:   begin
        ctrl.func        = FN_XOR;
        ctrl.carryEn     = 1'b1;
        ctrl.invB        = 1'b1;
        ctrl.carryPreset = 1'b1;
      end
      OP_STORE: begin ctrl.passB = 1'b0; ctrl.func = FN_XOR; end
      OP_JUMP:  begin ctrl.passA = 1'b0; ctrl.passB = 1'b0; ctrl.func = FN_ZERO; end
      default:  ctrl.func = FN_ZERO;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode)) begin
      // R6
      logic_no_carry_chk: assert (ctrl.func == FN_XOR || !ctrl.carryEn);
      // R4
      preset_needs_invb_chk: assert (!ctrl.carryPreset || (ctrl.invB && ctrl.carryEn));
    end
  end

endmodule

// File: rtl/serialAluDatapath.sv
module serialAluDatapath
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      wordStart,
  input  logic      aIn,
  input  logic      bIn,
  input  alu_ctrl_t ctrl,
  output logic      fOut,
  output logic      carryOut
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  logic             carryQ;
  logic [CNT_W-1:0] bitIdx;
  logic [CNT_W-1:0] curIdx;
  logic             lastBit;
  logic             opA, opB, cIn, sumBit, cNext, cStore;

  assign opA    = (aIn & ctrl.passA) ^ ctrl.invA;
  assign opB    = (bIn & ctrl.passB) ^ ctrl.invB;
  assign cIn    = ctrl.carryEn & (wordStart ? ctrl.carryPreset : carryQ);
  assign sumBit = opA ^ opB ^ cIn;
  assign cNext  = (opA & opB) | (cIn & (opA ^ opB));
  assign cStore = ctrl.carryEn & cNext;

  assign curIdx  = wordStart ? '0 : bitIdx;
  assign lastBit = (curIdx == LAST_IDX);

  always_comb begin
    unique case (ctrl.func)
      FN_XOR:  fOut = sumBit;
      FN_AND:  fOut = opA & opB;
      FN_OR:   fOut = opA | opB;
      default: fOut = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ   <= 1'b0;
      bitIdx   <= '0;
      carryOut <= 1'b0;
    end else if (bitValid) begin
      carryQ <= cStore;
      bitIdx <= lastBit ? '0 : curIdx + CNT_W'(1);
      if (lastBit) carryOut <= cStore;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> (!carryOut && !carryQ));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> ($stable(carryQ) && $stable(bitIdx) && $stable(carryOut)));

  // R3
  carry_out_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !lastBit) |=> $stable(carryOut));

endmodule

// File: rtl/serialAlu.sv
module serialAlu
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       wordStart,
  input  logic       aIn,
  input  logic       bIn,
  input  logic [2:0] opcode,
  output logic       fOut,
  output logic       carryOut
);

  alu_ctrl_t ctrl;

  serialAluDecode decode_i (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  serialAluDatapath #(.WIDTH(WIDTH)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (bitValid),
    .wordStart (wordStart),
    .aIn       (aIn),
    .bIn       (bIn),
    .ctrl      (ctrl),
    .fOut      (fOut),
    .carryOut  (carryOut)
  );

endmodule

// File: tb/serialAlu_tb_top.sv
`timescale 1ns/1ps
module serialAlu_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitValid = 1'b0;
  logic       wordStart = 1'b0;
  logic       aIn = 1'b0;
  logic       bIn = 1'b0;
  logic [2:0] opcode = 3'b000;
  logic       fOut;
  logic       carryOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serialAlu #(.WIDTH(8)) dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .wordStart(wordStart),
    .aIn(aIn), .bIn(bIn), .opcode(opcode), .fOut(fOut), .carryOut(carryOut)
  );

  // opcode, A, B
  localparam logic [18:0] VEC [12] = '{
    {3'b001, 8'hF0, 8'h3C},  // R2 and
    {3'b010, 8'hA5, 8'h0F},  // R2 or
    {3'b011, 8'hFF, 8'h5A},  // R2 xor
    {3'b100, 8'h12, 8'h34},  // R3 add no carry
    {3'b100, 8'hFF, 8'h01},  // R3 add carry
    {3'b100, 8'h80, 8'h80},  // R3 add carry, zero
    {3'b101, 8'h50, 8'h20},  // R4 sub no borrow
    {3'b101, 8'h20, 8'h50},  // R4 sub borrow
    {3'b101, 8'h77, 8'h77},  // R4 equal
    {3'b000, 8'h3E, 8'hC9},  // R5 load
    {3'b110, 8'h6D, 8'h92},  // R5 store
    {3'b111, 8'hFF, 8'hFF}   // R5 jump zero
  };

  function automatic logic [7:0] expF(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      3'b000: return b;
      3'b001: return a & b;
      3'b010: return a | b;
      3'b011: return a ^ b;
      3'b100: return a + b;
      3'b101: return a - b;
      3'b110: return a;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic expC(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (op == 3'b100) return s[8];
    if (op == 3'b101) return (a >= b);
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runWord(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input int gap, output logic [7:0] f, output logic c);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      opcode = op; bitValid = 1'b1; wordStart = (i == 0);
      aIn = a[i]; bIn = b[i];
      #0.5 f[i] = fOut;
      if (i == 3) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          bitValid = 1'b0; wordStart = (g == 0);
          aIn = ~aIn; bIn = (g % 2 == 0);
        end
      end
    end
    @(negedge clk);
    bitValid = 1'b0; wordStart = 1'b0; aIn = 1'b1; bIn = 1'b1;
    #0.5 c = carryOut;
  endtask

  task automatic wordCheck(input string req, input logic [2:0] op, input logic [7:0] a,
                           input logic [7:0] b, input int gap);
    logic [7:0] f;
    logic c;
    runWord(op, a, b, gap, f, c);
    check(f == expF(op, a, b), req, f, expF(op, a, b));
    check(c == expC(op, a, b), {req, " carry"}, c, expC(op, a, b));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5 check(carryOut == 1'b0, "R1 reset", carryOut, 0);
    @(negedge clk) rstN = 1'b1;
    #0.5 check(carryOut == 1'b0, "R1 after release", carryOut, 0);

    for (int v = 0; v < 12; v++) begin
      logic [18:0] e;
      e = VEC[v];
      wordCheck("R2/R3/R4/R5 vector", e[18:16], e[15:8], e[7:0], 0);
    end

    // R7: add leaves carry 1, next add must start from 0
    wordCheck("R7 add after carry", 3'b100, 8'hFF, 8'h01, 0);
    wordCheck("R7 add preset clear", 3'b100, 8'h00, 8'h00, 0);
    // R7: subtract preset 1 after a carry-0 word
    wordCheck("R7 sub preset", 3'b101, 8'h05, 8'h05, 0);
    // R6: logic after a carrying add
    wordCheck("R6 setup", 3'b100, 8'hC0, 8'h40, 0);
    wordCheck("R6 and after carry", 3'b001, 8'hFF, 8'hFF, 0);
    wordCheck("R6 setup2", 3'b100, 8'hFF, 8'hFF, 0);
    wordCheck("R6 load after carry", 3'b000, 8'h00, 8'h81, 0);
    // R8: idle cycles inside a word
    wordCheck("R8 gapped add", 3'b100, 8'hC8, 8'h5A, 3);
    wordCheck("R8 gapped sub", 3'b101, 8'h13, 8'h2F, 2);

    // R1: reset after a carrying word
    wordCheck("R1 setup", 3'b100, 8'hF0, 8'h20, 0);
    @(negedge clk) rstN = 1'b0;
    #0.5 check(carryOut == 1'b0, "R1 mid reset", carryOut, 0);
    @(negedge clk) rstN = 1'b1;
    wordCheck("R1 add after reset", 3'b100, 8'h01, 8'h02, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule